// File: doc/BRIEF.md
# MDIO Paged Register Bridge

This block is a management-bus slave. It lets a host that only issues ordinary 16-bit Clause 22 MDIO frames reach a 32-bit internal register space that is wider than the frame format allows. The top two bits of the 5-bit PHY address in each frame pick what the frame does. A frame can load a page register that supplies the upper address bits. It can read or write one 16-bit half of a 32-bit register. It can also be handed on to an internal PHY as a pass-through request.

The block runs on MDC alone. The 32-bit register file sits behind a simple strobe bus. A write reaches that bus only when both halves are known, so the low half is held until the high half arrives. A read fetches all 32 bits when the low half is read. A read of the high half that follows returns the upper bits from that same fetch, so software always sees a coherent word. The MDIO pad is split into input, output and output-enable. The tri-state buffer is outside the block.

Top module: `mdio_paged_bridge`

## Requirements
- R1: A frame is accepted only after at least PRE_LEN consecutive 1 bits, followed by start bits 0,1. Opcode 01 is a write and opcode 10 is a read. Bits are sampled on the rising edge of MDC. After fewer than PRE_LEN ones the frame produces no request and no drive.
- R2: The two most significant PHY address bits set the frame's mode: 11 is page select, 10 is register access, 00 is pass-through. The value 01 makes the frame ignored. An ignored frame issues no request, does not drive MDIO and leaves the page unchanged.
- R3: A page-select write stores data bits [PAGE_W-1:0] as the page. The low PHY address bits and the register number of that frame are don't-care. The page is cleared to 0 by reset.
- R4: In register mode the bus address is {page, PHY address[2:0], register number[4:1], 2'b00}. Register number bit 0 selects the half: 0 is the low half, 1 is the high half.
- R5: A write to a low half is staged and issues no bus write. A write to a high half pulses bus_we for one cycle, in the cycle after the last data bit is sampled, with bus_wdata = {high data, staged low data}.
- R6: A read of a low half pulses bus_re for one cycle during the first turnaround bit. bus_rdata is taken in that cycle, and bits [15:0] are returned.
- R7: A read of a high half issues no bus read. It returns bits [31:16] of the word captured by the most recent low-half read.
- R8: MDIO is driven only for register-mode reads. It is driven 0 in the second turnaround bit, then carries the 16 data bits MSB first, each bit changing after a rising MDC edge. It is released after the last data bit.
- R9: A read in page-select mode does not return the page. It issues no request and does not drive MDIO.
- R10: In pass-through mode a byp_req pulse carries PHY address[2:0], the unchanged register number and the direction. The pulse comes in the first turnaround bit for a read, and in the cycle after the last data bit for a write, together with the write data. The bridge never drives MDIO for such a frame. At most one of bus_we, bus_re and byp_req is high in any cycle.
- R11: A frame with opcode 00 or 11 is ignored. It issues no request and does not drive MDIO.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mdc | input | 1 | Management clock. Bits are sampled on its rising edge. |
| rst_n | input | 1 | Asynchronous active-low reset. Clears the page. |
| mdio_i | input | 1 | MDIO level from the pad. |
| mdio_o | output | 1 | MDIO value driven when mdio_oe is high. |
| mdio_oe | output | 1 | Output enable for the MDIO pad. |
| bus_addr | output | PAGE_W+9 | Byte address of the 32-bit register. |
| bus_wdata | output | 32 | Assembled write word. |
| bus_we | output | 1 | One-cycle register write strobe. |
| bus_re | output | 1 | One-cycle register read strobe. |
| bus_rdata | input | 32 | Read word, valid in the bus_re cycle. |
| byp_req | output | 1 | Pass-through request pulse. |
| byp_write | output | 1 | Pass-through direction, 1 for a write. |
| byp_phy | output | 3 | Internal PHY selected by the pass-through frame. |
| byp_reg | output | 5 | Register number of the pass-through frame. |
| byp_wdata | output | 16 | Data of a pass-through write. |

## Verification
The bench builds the block with PAGE_W = 10 and PRE_LEN = 32. With these values it writes the widest page, 0x3FF, and sees it show up in the top address bits [18:9]. It also runs a 31-bit preamble next to a 33-bit one, which checks the acceptance threshold from both sides. A bench-side register model answers each read with a word derived from the address. Comparing low and high halves against that model therefore checks the address formation and the coherent capture of the word together.

// File: rtl/mdb_pkg.sv
package mdb_pkg;

  localparam int HALF_W = 16;
  localparam int HDR_W  = 12;

  typedef enum logic [1:0] {
    MODE_PASS = 2'b00,
    MODE_RSVD = 2'b01,
    MODE_REG  = 2'b10,
    MODE_PAGE = 2'b11
  } mdb_mode_e;

  localparam logic [1:0] OP_WR = 2'b01;
  localparam logic [1:0] OP_RD = 2'b10;

  // Header fields in arrival order: opcode first, register number last.
  typedef struct packed {
    logic [1:0] op;
    logic [4:0] phy;
    logic [4:0] rg;
  } mdb_hdr_t;

  function automatic mdb_mode_e mode_of(input mdb_hdr_t h);
    return mdb_mode_e'(h.phy[4:3]);
  endfunction

  // Address bits below the page: word-aligned byte offset within a page.
  function automatic logic [8:0] in_page_addr(input mdb_hdr_t h);
    return {h.phy[2:0], h.rg[4:1], 2'b00};
  endfunction

  function automatic logic is_high_half(input mdb_hdr_t h);
    return h.rg[0];
  endfunction

endpackage

// File: rtl/mdb_frame_rx.sv
module mdb_frame_rx
  import mdb_pkg::*;
#(
  parameter int PRE_LEN = 32
) (
  input  logic              mdc,
  input  logic              rst_n,
  input  logic              mdio_i,
  input  logic              drive_en,
  input  logic [HALF_W-1:0] rd_half,
  output mdb_hdr_t          hdr_q,
  output logic              hdr_done_q,
  output logic              frame_done_q,
  output logic [HALF_W-1:0] din_q,
  output logic              mdio_o,
  output logic              mdio_oe
);

  localparam int CNT_W = $clog2(PRE_LEN + 1);
  localparam logic [CNT_W-1:0] PRE_MAX = CNT_W'(PRE_LEN);
  localparam logic [3:0] HDR_LAST  = 4'(HDR_W - 1);
  localparam logic [3:0] DATA_LAST = 4'(HALF_W - 1);

  typedef enum logic [2:0] {FR_IDLE, FR_ST1, FR_HDR, FR_TA, FR_DATA} fr_state_e;

  fr_state_e         state_q;
  logic [CNT_W-1:0]  pre_cnt_q;
  logic [3:0]        bcnt_q;
  logic [HALF_W-1:0] shreg_q;

  always_ff @(posedge mdc or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= FR_IDLE;
      pre_cnt_q    <= '0;
      bcnt_q       <= '0;
      hdr_q        <= '0;
      din_q        <= '0;
      shreg_q      <= '0;
      mdio_o       <= 1'b0;
      mdio_oe      <= 1'b0;
      hdr_done_q   <= 1'b0;
      frame_done_q <= 1'b0;
    end else begin
      hdr_done_q   <= 1'b0;
      frame_done_q <= 1'b0;
      unique case (state_q)
        FR_IDLE: begin
          if (mdio_i) begin
            if (pre_cnt_q != PRE_MAX) pre_cnt_q <= pre_cnt_q + 1'b1;
          end else begin
            if (pre_cnt_q == PRE_MAX) state_q <= FR_ST1;
            pre_cnt_q <= '0;
          end
        end
        FR_ST1: begin
          bcnt_q  <= '0;
          state_q <= mdio_i ? FR_HDR : FR_IDLE;
        end
        FR_HDR: begin
          hdr_q <= mdb_hdr_t'({hdr_q[HDR_W-2:0], mdio_i});
          if (bcnt_q == HDR_LAST) begin
            bcnt_q     <= '0;
            state_q    <= FR_TA;
            hdr_done_q <= 1'b1;
          end else begin
            bcnt_q <= bcnt_q + 1'b1;
          end
        end
        FR_TA: begin
          if (bcnt_q == 4'd0) begin
            bcnt_q <= 4'd1;
            if (drive_en) begin
              mdio_oe <= 1'b1;
              mdio_o  <= 1'b0;
              shreg_q <= rd_half;
            end
          end else begin
            bcnt_q  <= '0;
            state_q <= FR_DATA;
            if (mdio_oe) begin
              mdio_o  <= shreg_q[HALF_W-1];
              shreg_q <= {shreg_q[HALF_W-2:0], 1'b0};
            end
          end
        end
        FR_DATA: begin
          din_q <= {din_q[HALF_W-2:0], mdio_i};
          if (bcnt_q == DATA_LAST) begin
            bcnt_q       <= '0;
            state_q      <= FR_IDLE;
            mdio_oe      <= 1'b0;
            mdio_o       <= 1'b0;
            frame_done_q <= 1'b1;
          end else begin
            bcnt_q <= bcnt_q + 1'b1;
            if (mdio_oe) begin
              mdio_o  <= shreg_q[HALF_W-1];
              shreg_q <= {shreg_q[HALF_W-2:0], 1'b0};
            end
          end
        end
        default: state_q <= FR_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/mdb_page_store.sv
module mdb_page_store #(
  parameter int PAGE_W = 10
) (
  input  logic              mdc,
  input  logic              rst_n,
  input  logic              we,
  input  logic [PAGE_W-1:0] din,
  output logic [PAGE_W-1:0] page_q
);

  always_ff @(posedge mdc or negedge rst_n) begin
    if (!rst_n)  page_q <= '0;
    else if (we) page_q <= din;
  end

endmodule

// File: rtl/mdb_half_merge.sv
module mdb_half_merge
  import mdb_pkg::*;
(
  input  logic                mdc,
  input  logic                rst_n,
  input  logic                stage_we,
  input  logic [HALF_W-1:0]   stage_din,
  input  logic                cap_we,
  input  logic [2*HALF_W-1:0] cap_din,
  input  logic                sel_high,
  output logic [HALF_W-1:0]   stage_q,
  output logic [HALF_W-1:0]   rd_half
);

  logic [HALF_W-1:0] cap_hi_q;

  always_ff @(posedge mdc or negedge rst_n) begin
    if (!rst_n) begin
      stage_q  <= '0;
      cap_hi_q <= '0;
    end else begin
      if (stage_we) stage_q  <= stage_din;
      if (cap_we)   cap_hi_q <= cap_din[2*HALF_W-1:HALF_W];
    end
  end

  // Low half comes straight from the bus in the strobe cycle.
  assign rd_half = sel_high ? cap_hi_q : cap_din[HALF_W-1:0];

endmodule

// File: rtl/mdio_paged_bridge.sv
module mdio_paged_bridge
  import mdb_pkg::*;
#(
  parameter int PAGE_W  = 10,
  parameter int PRE_LEN = 32,
  localparam int ADDR_W = PAGE_W + 9
) (
  input  logic                mdc,
  input  logic                rst_n,
  input  logic                mdio_i,
  output logic                mdio_o,
  output logic                mdio_oe,
  output logic [ADDR_W-1:0]   bus_addr,
  output logic [2*HALF_W-1:0] bus_wdata,
  output logic                bus_we,
  output logic                bus_re,
  input  logic [2*HALF_W-1:0] bus_rdata,
  output logic                byp_req,
  output logic                byp_write,
  output logic [2:0]          byp_phy,
  output logic [4:0]          byp_reg,
  output logic [HALF_W-1:0]   byp_wdata
);

  mdb_hdr_t          hdr;
  logic              hdr_done;
  logic              frame_done;
  logic [HALF_W-1:0] din;
  logic [HALF_W-1:0] stage_q;
  logic [HALF_W-1:0] rd_half;
  logic [PAGE_W-1:0] page_q;

  mdb_mode_e mode;
  logic      is_wr, is_rd, hi_half;
  logic      page_we, stage_we, drive_en;

  assign mode    = mode_of(hdr);
  assign is_wr   = (hdr.op == OP_WR);
  assign is_rd   = (hdr.op == OP_RD);
  assign hi_half = is_high_half(hdr);

  assign page_we  = frame_done && is_wr && (mode == MODE_PAGE);
  assign stage_we = frame_done && is_wr && (mode == MODE_REG) && !hi_half;
  assign bus_we   = frame_done && is_wr && (mode == MODE_REG) &&  hi_half;
  assign bus_re   = hdr_done   && is_rd && (mode == MODE_REG) && !hi_half;
  assign drive_en = is_rd && (mode == MODE_REG);
  assign byp_req  = (mode == MODE_PASS) &&
                    ((hdr_done && is_rd) || (frame_done && is_wr));

  assign bus_addr  = {page_q, in_page_addr(hdr)};
  assign bus_wdata = {din, stage_q};
  assign byp_write = is_wr;
  assign byp_phy   = hdr.phy[2:0];
  assign byp_reg   = hdr.rg;
  assign byp_wdata = din;

  mdb_frame_rx #(.PRE_LEN(PRE_LEN)) u_rx (
    .mdc          (mdc),
    .rst_n        (rst_n),
    .mdio_i       (mdio_i),
    .drive_en     (drive_en),
    .rd_half      (rd_half),
    .hdr_q        (hdr),
    .hdr_done_q   (hdr_done),
    .frame_done_q (frame_done),
    .din_q        (din),
    .mdio_o       (mdio_o),
    .mdio_oe      (mdio_oe)
  );

  mdb_page_store #(.PAGE_W(PAGE_W)) u_page (
    .mdc    (mdc),
    .rst_n  (rst_n),
    .we     (page_we),
    .din    (din[PAGE_W-1:0]),
    .page_q (page_q)
  );

  mdb_half_merge u_merge (
    .mdc       (mdc),
    .rst_n     (rst_n),
    .stage_we  (stage_we),
    .stage_din (din),
    .cap_we    (bus_re),
    .cap_din   (bus_rdata),
    .sel_high  (hi_half),
    .stage_q   (stage_q),
    .rd_half   (rd_half)
  );

endmodule

// File: rtl/mdb_bridge_chk.sv
module mdb_bridge_chk #(
  parameter int PAGE_W = 10
) (
  input logic              mdc,
  input logic              rst_n,
  input logic              mdio_oe,
  input logic              mdio_o,
  input logic              bus_we,
  input logic              bus_re,
  input logic              byp_req,
  input logic [11:0]       hdr_bits,
  input logic              page_we,
  input logic [PAGE_W-1:0] page_q
);

  AST_DRIVE_ONLY_REG_READ: assert property (@(posedge mdc) disable iff (!rst_n)
    mdio_oe |-> (hdr_bits[9:8] == 2'b10 && hdr_bits[11:10] == 2'b10)); // R8

  AST_TA_DRIVES_LOW: assert property (@(posedge mdc) disable iff (!rst_n)
    $rose(mdio_oe) |-> !mdio_o); // R8

  AST_READ_THEN_DRIVE: assert property (@(posedge mdc) disable iff (!rst_n)
    bus_re |=> mdio_oe); // R6

  AST_ONE_REQUEST: assert property (@(posedge mdc) disable iff (!rst_n)
    $onehot0({bus_we, bus_re, byp_req})); // R10

  AST_PAGE_HOLD: assert property (@(posedge mdc) disable iff (!rst_n)
    !page_we |=> $stable(page_q)); // R3

  AST_RSVD_SILENT: assert property (@(posedge mdc) disable iff (!rst_n)
    (hdr_bits[9:8] == 2'b01) |-> !(bus_we || bus_re || byp_req || mdio_oe)); // R2

  AST_WE_PULSE: assert property (@(posedge mdc) disable iff (!rst_n)
    bus_we |=> !bus_we); // R5

endmodule

bind mdio_paged_bridge mdb_bridge_chk #(.PAGE_W(PAGE_W)) u_chk (
  .mdc      (mdc),
  .rst_n    (rst_n),
  .mdio_oe  (mdio_oe),
  .mdio_o   (mdio_o),
  .bus_we   (bus_we),
  .bus_re   (bus_re),
  .byp_req  (byp_req),
  .hdr_bits (hdr),
  .page_we  (page_we),
  .page_q   (page_q)
);

// File: tb/mdio_paged_bridge_test.sv
`timescale 1ns/1ps
module mdio_paged_bridge_test;

  localparam int PAGE_W = 10;
  localparam int PRE_LEN = 32;
  localparam int AW = PAGE_W + 9;

  logic          mdc = 1'b0;
  logic          rst_n = 1'b0;
  logic          mdio_i = 1'b1;
  logic          mdio_o, mdio_oe, bus_we, bus_re, byp_req, byp_write;
  logic [AW-1:0] bus_addr;
  logic [31:0]   bus_wdata, bus_rdata;
  logic [2:0]    byp_phy;
  logic [4:0]    byp_reg;
  logic [15:0]   byp_wdata;

  always #2.5 mdc = ~mdc;

  function automatic logic [31:0] model_val(input logic [18:0] a);
    return {a[15:0] ^ 16'hC35A, a[18:3] ^ 16'h0F0F};
  endfunction

  // R4 address rule restated arithmetically
  function automatic logic [18:0] eaddr(input logic [9:0] p, input logic [2:0] ph,
                                        input logic [4:0] rg);
    return 19'(p) * 19'd512 + 19'(ph) * 19'd64 + 19'(rg >> 1) * 19'd4;
  endfunction

  assign bus_rdata = model_val(bus_addr);

  mdio_paged_bridge #(.PAGE_W(PAGE_W), .PRE_LEN(PRE_LEN)) uut (
    .mdc(mdc), .rst_n(rst_n), .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_re(bus_re),
    .bus_rdata(bus_rdata), .byp_req(byp_req), .byp_write(byp_write),
    .byp_phy(byp_phy), .byp_reg(byp_reg), .byp_wdata(byp_wdata)
  );

  typedef struct packed {
    logic [1:0]  kind;   // 0 bus write, 1 bus read, 2 bypass read, 3 bypass write
    logic [18:0] addr;
    logic [31:0] data;
  } item_t;

  item_t expq[$];
  string tagq[$];
  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done = 1'b0;

  localparam logic [18:0] DRIVE_TRACE = 19'h3FFFE;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [1:0] k, input logic [18:0] a, input logic [31:0] d,
                      input string tag);
    expq.push_back('{kind: k, addr: a, data: d});
    tagq.push_back(tag);
  endtask

  // Monitor: compares each request seen on the bus against the queue
  always @(negedge mdc) begin
    int    nev;
    item_t obs, exp_i;
    string tg;
    if (rst_n && !done) begin
      nev = int'(bus_we) + int'(bus_re) + int'(byp_req);
      if (nev > 1) check("R10 single request", 32'(nev), 32'd1);
      if (nev == 1) begin
        if (bus_we)      obs = '{kind: 2'd0, addr: bus_addr, data: bus_wdata};
        else if (bus_re) obs = '{kind: 2'd1, addr: bus_addr, data: 32'h0};
        else obs = '{kind: byp_write ? 2'd3 : 2'd2, addr: {11'h0, byp_phy, byp_reg},
                     data: byp_write ? {16'h0, byp_wdata} : 32'h0};
        n_cmp++;
        if (expq.size() == 0) begin
          n_bad++;
          $display("FAIL R2 unexpected request actual=%h expected=none", obs);
        end else begin
          exp_i = expq.pop_front();
          tg = tagq.pop_front();
          if (obs !== exp_i) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tg, obs, exp_i);
          end
        end
      end
    end
  end

  task automatic slot(input logic b);
    @(negedge mdc);
    mdio_i = b;
  endtask

  task automatic run(input int pre, input logic [1:0] op, input logic [4:0] phy,
                     input logic [4:0] rg, input logic [15:0] wd,
                     output logic [15:0] rd, output logic [18:0] oet, output logic ta2o);
    bit rdph;
    rdph = (op == 2'b10);
    for (int i = 0; i < pre; i++) slot(1'b1);
    slot(1'b0);
    slot(1'b1);
    slot(op[1]);
    slot(op[0]);
    for (int i = 4; i >= 0; i--) slot(phy[i]);
    for (int i = 4; i >= 0; i--) slot(rg[i]);
    @(negedge mdc); oet[18] = mdio_oe; mdio_i = 1'b1;
    @(negedge mdc); oet[17] = mdio_oe; ta2o = mdio_o; mdio_i = rdph ? 1'b1 : 1'b0;
    for (int i = 15; i >= 0; i--) begin
      @(negedge mdc);
      oet[i+1] = mdio_oe;
      rd[i] = mdio_o;
      mdio_i = rdph ? 1'b1 : wd[i];
    end
    @(negedge mdc); oet[0] = mdio_oe; mdio_i = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge mdc);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL R1 watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] r;
    logic [18:0] tr;
    logic        ta;
    logic [9:0]  pg;
    logic [18:0] a;

    repeat (4) @(negedge mdc);
    check("R3 reset oe", 32'(mdio_oe), 32'd0);
    check("R3 reset strobes", {29'h0, bus_we, bus_re, byp_req}, 32'd0);
    rst_n = 1'b1;
    pg = 10'h0;

    // R6 R8 low read with reset page
    a = eaddr(pg, 3'd2, 5'b00100);
    push(2'd1, a, 32'h0, "R6 low read strobe");
    run(32, 2'b10, 5'b10010, 5'b00100, 16'h0, r, tr, ta);
    check("R6 low half data", 32'(r), 32'(model_val(a)[15:0]));
    check("R8 drive trace", 32'(tr), 32'(DRIVE_TRACE));
    check("R8 turnaround zero", 32'(ta), 32'd0);

    // R7 high half from capture
    run(32, 2'b10, 5'b10010, 5'b00101, 16'h0, r, tr, ta);
    check("R7 high half data", 32'(r), 32'(model_val(a)[31:16]));

    // R3 page write of the widest value, upper data bits dropped
    run(32, 2'b01, 5'b11000, 5'b00000, 16'hFFFF, r, tr, ta);
    check("R8 no drive on page write", 32'(tr), 32'd0);
    pg = 10'h3FF;

    // R5 staged low write, then assembled high write
    run(32, 2'b01, 5'b10101, 5'b01010, 16'h1234, r, tr, ta);
    push(2'd0, eaddr(pg, 3'd5, 5'b01010), 32'hABCD1234, "R5 assembled write");
    run(32, 2'b01, 5'b10101, 5'b01011, 16'hABCD, r, tr, ta);

    // R2 reserved mode write ignored, page kept
    run(32, 2'b01, 5'b01000, 5'b00000, 16'h0001, r, tr, ta);
    check("R2 reserved mode no drive", 32'(tr), 32'd0);
    push(2'd1, eaddr(pg, 3'd0, 5'b00000), 32'h0, "R2 page kept after reserved frame");
    run(32, 2'b10, 5'b10000, 5'b00000, 16'h0, r, tr, ta);
    check("R4 paged read data", 32'(r), 32'(model_val(eaddr(pg, 3'd0, 5'b00000))[15:0]));

    // R9 page register not readable
    run(32, 2'b10, 5'b11000, 5'b00000, 16'h0, r, tr, ta);
    check("R9 page read no drive", 32'(tr), 32'd0);

    // R10 pass-through
    push(2'd3, {11'h0, 3'b011, 5'b00111}, 32'h000055AA, "R10 bypass write");
    run(32, 2'b01, 5'b00011, 5'b00111, 16'h55AA, r, tr, ta);
    push(2'd2, {11'h0, 3'b110, 5'b11111}, 32'h0, "R10 bypass read");
    run(32, 2'b10, 5'b00110, 5'b11111, 16'h0, r, tr, ta);
    check("R10 bypass no drive", 32'(tr), 32'd0);

    // R11 undefined opcodes
    run(32, 2'b11, 5'b10001, 5'b00000, 16'hFFFF, r, tr, ta);
    check("R11 opcode 11 no drive", 32'(tr), 32'd0);
    run(32, 2'b00, 5'b10001, 5'b00010, 16'hFFFF, r, tr, ta);
    check("R11 opcode 00 no drive", 32'(tr), 32'd0);

    // R1 preamble threshold
    run(31, 2'b10, 5'b10001, 5'b00010, 16'h0, r, tr, ta);
    check("R1 short preamble no drive", 32'(tr), 32'd0);
    a = eaddr(pg, 3'd1, 5'b00010);
    push(2'd1, a, 32'h0, "R1 long preamble accepted");
    run(33, 2'b10, 5'b10001, 5'b00010, 16'h0, r, tr, ta);
    check("R1 long preamble data", 32'(r), 32'(model_val(a)[15:0]));

    // R7 new capture replaces the old one
    a = eaddr(pg, 3'd7, 5'b11110);
    push(2'd1, a, 32'h0, "R6 low read top address");
    run(32, 2'b10, 5'b10111, 5'b11110, 16'h0, r, tr, ta);
    run(32, 2'b10, 5'b10111, 5'b11111, 16'h0, r, tr, ta);
    check("R7 high half after new capture", 32'(r), 32'(model_val(a)[31:16]));

    // R3 reset clears the page
    @(negedge mdc); rst_n = 1'b0;
    repeat (3) @(negedge mdc);
    check("R3 oe in reset", 32'(mdio_oe), 32'd0);
    rst_n = 1'b1;
    pg = 10'h0;
    push(2'd1, eaddr(pg, 3'd0, 5'b00000), 32'h0, "R3 page cleared by reset");
    run(32, 2'b10, 5'b10000, 5'b00000, 16'h0, r, tr, ta);

    repeat (4) @(negedge mdc);
    check("R5 expected requests drained", 32'(expq.size()), 32'd0);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule